// File: doc/BRIEF.md
# DSI Command-Mode Packet Engine

This block is the command-mode transmit and read-back engine of a DSI host controller. Software fills a small word-addressed command queue, writes a queue-size value and writes the start bit. The engine then reads queue word 0 and decides between a short and a long packet. It streams the packet header and payload bytes to a serializer through a valid/ready byte handshake. For a read command it then hands the link over with a one-cycle bus-turnaround pulse and captures the peripheral's response bytes into four RX data words. ECC, checksum and the physical layer are outside the block.

Completion is reported through a two-flag status word with a busy bit, and an active-low level interrupt follows the enabled flags. After a read the engine stays busy until software writes the read-acknowledge bit. Software uses that window to collect the RX words.

The controller has five states. ST_IDLE waits for an accepted start and moves to ST_SEND. ST_SEND emits one byte per accepted handshake. After the last byte it returns to ST_IDLE for a write command or goes to ST_TURN for a read. ST_TURN lasts one cycle, raises the turnaround pulse and moves to ST_LISTEN. ST_LISTEN captures response bytes until the byte marked last, then moves to ST_HOLD. ST_HOLD returns to ST_IDLE when the acknowledge is written.

Top module: `dsi_cq_engine`

Register word addresses: 0 start (bit 0), 1 interrupt enable, 2 status, 3 mode, 4 queue size (6 bits), 5 read acknowledge (bit 0), 8 to 11 RX data words, 32 upward the command queue.

## Requirements
- R1: After reset the status word reads 0, the interrupt line is high (inactive), and tx_valid and bta_o are low.
- R2: Queue word 0 has bits 1:0 = 0 (short packet), bits 15:8 = data ID, bits 23:16 = first parameter and bits 31:24 = second parameter. For such a word the engine emits exactly three bytes: the data ID, then the first parameter, then the second parameter. tx_last is high only with the third byte.
- R3: When word 0 bits 1:0 = 2 (long packet), bits 31:16 hold the payload count N. The engine emits the data ID, then N[7:0], then N[15:8], then N payload bytes read little-endian from queue byte offset 4 upward. N = 0 gives only the three header bytes. tx_last is high only with the final byte.
- R4: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte stays unchanged into the next cycle.
- R5: A start write is ignored if the mode register is nonzero, if the queue size is 0, or if the engine is busy. An ignored start produces no bytes and leaves busy low when the engine was idle.
- R6: Status bit 31 (busy) is 1 from the accepted start until the command finishes. A write command finishes when its last byte is accepted, and at that point status bit 1 (done) becomes 1.
- R7: When word 0 bit 2 is set (read), the engine raises bta_o for exactly one cycle after the last byte is accepted, and never while tx_valid is high.
- R8: Response byte k is stored at RX word k/4, bits 8*(k%4)+7 down to 8*(k%4). Bytes with k of 14 or more are discarded. All RX words are cleared when a read command starts.
- R9: The response byte marked rx_last sets status bits 0 (read ready) and 1 (done). Busy then stays 1 until a write of 1 to bit 0 of the acknowledge register; a write of 0 there has no effect.
- R10: A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R11: irq_n is low exactly when some status flag is 1 and its interrupt-enable bit (same position) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_byte | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte is the last of the packet |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| bta_o | output | 1 | One-cycle bus-turnaround request |
| rx_valid | input | 1 | Response byte present |
| rx_byte | input | 8 | Response byte |
| rx_last | input | 1 | Response byte is the final one |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The bench uses the default build: a 16-word queue, a 16-byte response area with 14 kept, and a 6-bit address. With the 16-word queue, every long-packet length from 0 to 12 bytes can be swept, which covers each residue of the word split and the empty payload. The 16-byte response area lets the read sweep run from 16 bytes down to 1 byte, so the 14-byte cap is crossed and the clear-on-start behaviour shows up in every step. Each sweep also alternates among three serializer back-pressure patterns, so the hold rule is tested during short headers, long headers and payload bytes.

// File: rtl/dsi_cq_pkg.sv
package dsi_cq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_TURN,
        ST_LISTEN,
        ST_HOLD
    } cq_state_t;

    // register word addresses
    localparam int REG_START = 0;
    localparam int REG_IEN   = 1;
    localparam int REG_STAT  = 2;
    localparam int REG_MODE  = 3;
    localparam int REG_QSIZE = 4;
    localparam int REG_RACK  = 5;
    localparam int REG_RX0   = 8;

    // status flag positions
    localparam int FLAG_RDY  = 0;
    localparam int FLAG_DONE = 1;
    localparam int NFLAG     = 2;
    localparam int BUSY_BIT  = 31;

    // queue word 0 config field
    localparam logic [1:0] CFG_LONG = 2'd2;
    localparam int CFG_TURN_BIT = 2;

endpackage

// File: rtl/dsi_cq_txsel.sv
module dsi_cq_txsel #(
    parameter int QDEPTH = 16,
    parameter int BA_W   = $clog2(QDEPTH * 4)
) (
    input  logic [QDEPTH-1:0][31:0] q_words,
    input  logic [BA_W-1:0]         byte_addr,
    output logic [7:0]              byte_o
);
    localparam int WI_W = BA_W - 2;

    logic [QDEPTH-1:0][7:0] lane_sel;
    logic [WI_W-1:0]        word_idx;

    // per-word byte lane pick, then word pick
    generate
        for (genvar gw = 0; gw < QDEPTH; gw++) begin : g_word
            assign lane_sel[gw] = q_words[gw][8*byte_addr[1:0] +: 8];
        end
    endgenerate

    assign word_idx = byte_addr[BA_W-1:2];
    assign byte_o   = lane_sel[word_idx];

endmodule

// File: rtl/dsi_cq_rxcap.sv
module dsi_cq_rxcap #(
    parameter int RX_BYTES = 16,
    parameter int KEEP     = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_byte,
    output logic [RX_BYTES/4-1:0][31:0]  rx_words
);
    localparam int IDX_W = $clog2(RX_BYTES) + 1;

    logic [RX_BYTES-1:0][7:0] buf_q;
    logic [IDX_W-1:0]         idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            buf_q <= '0;
            idx_q <= '0;
        end else if (rx_valid && (idx_q < IDX_W'(KEEP))) begin
            buf_q[idx_q[IDX_W-2:0]] <= rx_byte;
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign rx_words = buf_q;

    // R8
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rx_words == '0));

endmodule

// File: rtl/dsi_cq_irq.sv
module dsi_cq_irq #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic          wr_en,
    input  logic [NF-1:0] wr_keep,
    input  logic [NF-1:0] enable,
    output logic [NF-1:0] flags,
    output logic          irq_n
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (wr_en ? (flags & wr_keep) : flags) | set;
        end
    end

    assign irq_n = ~|(flags & enable);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set)));

endmodule

// File: rtl/dsi_cq_engine.sv
module dsi_cq_engine
    import dsi_cq_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int QDEPTH   = 16,
    parameter int QBASE    = 32,
    parameter int RX_BYTES = 16,
    parameter int RX_KEEP  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              bta_o,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic              irq_n
);
    localparam int BA_W   = $clog2(QDEPTH * 4);
    localparam int QIDX_W = $clog2(QDEPTH);
    localparam int RXW    = RX_BYTES / 4;
    localparam int RXI_W  = $clog2(RXW);
    localparam int LEN_W  = 17;
    localparam int QSZ_W  = 6;

    cq_state_t state_q, state_d;

    logic [QDEPTH-1:0][31:0] q_words;
    logic [NFLAG-1:0]        int_en_q;
    logic [1:0]              mode_q;
    logic [QSZ_W-1:0]        qsize_q;
    logic [LEN_W-1:0]        cnt_q, last_idx_q;
    logic                    rd_cmd_q;
    logic [NFLAG-1:0]        flags, flag_set;
    logic [RXW-1:0][31:0]    rx_words;

    logic              q_hit, rx_hit;
    logic [QIDX_W-1:0] qidx;
    logic [RXI_W-1:0]  rxidx;
    logic              start_wr, start_ok, ack_hit, stat_wr;
    logic              send_done, rx_end, busy;
    logic [31:0]       word0;
    logic              w0_long, w0_read;
    logic [LEN_W-1:0]  w0_last;

    // ---------------- address decode ----------------
    assign q_hit  = (int'(reg_addr) >= QBASE) && (int'(reg_addr) < QBASE + QDEPTH);
    assign qidx   = QIDX_W'(reg_addr - ADDR_W'(QBASE));
    assign rx_hit = (int'(reg_addr) >= REG_RX0) && (int'(reg_addr) < REG_RX0 + RXW);
    assign rxidx  = RXI_W'(reg_addr - ADDR_W'(REG_RX0));

    assign start_wr = reg_we && (reg_addr == ADDR_W'(REG_START)) && reg_wdata[0];
    assign ack_hit  = reg_we && (reg_addr == ADDR_W'(REG_RACK)) && reg_wdata[0];
    assign stat_wr  = reg_we && (reg_addr == ADDR_W'(REG_STAT));

    // ---------------- queue word 0 decode ----------------
    assign word0   = q_words[0];
    assign w0_long = (word0[1:0] == CFG_LONG);
    assign w0_read = word0[CFG_TURN_BIT];
    assign w0_last = w0_long ? ({1'b0, word0[31:16]} + LEN_W'(2)) : LEN_W'(2);

    assign start_ok = start_wr && (state_q == ST_IDLE) && (mode_q == 2'd0)
                      && (qsize_q != '0);
    assign send_done = (state_q == ST_SEND) && tx_ready && (cnt_q == last_idx_q);
    assign rx_end    = (state_q == ST_LISTEN) && rx_valid && rx_last;

    // ---------------- software registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_words  <= '0;
            int_en_q <= '0;
            mode_q   <= '0;
            qsize_q  <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (q_hit && (qidx == QIDX_W'(i))) q_words[i] <= reg_wdata;
            end
            if (reg_addr == ADDR_W'(REG_IEN))   int_en_q <= reg_wdata[NFLAG-1:0];
            if (reg_addr == ADDR_W'(REG_MODE))  mode_q   <= reg_wdata[1:0];
            if (reg_addr == ADDR_W'(REG_QSIZE)) qsize_q  <= reg_wdata[QSZ_W-1:0];
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_SEND;
            ST_SEND:   if (send_done) state_d = rd_cmd_q ? ST_TURN : ST_IDLE;
            ST_TURN:   state_d = ST_LISTEN;
            ST_LISTEN: if (rx_end) state_d = ST_HOLD;
            ST_HOLD:   if (ack_hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- command datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            last_idx_q <= '0;
            rd_cmd_q   <= 1'b0;
        end else if (start_ok) begin
            cnt_q      <= '0;
            last_idx_q <= w0_last;
            rd_cmd_q   <= w0_read;
        end else if ((state_q == ST_SEND) && tx_ready && !send_done) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        bta_o    = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = (cnt_q == last_idx_q);
            end
            ST_TURN:   bta_o = 1'b1;
            ST_LISTEN: ;
            ST_HOLD:   ;
            default:   busy = 1'b0;
        endcase
    end

    // byte n of the stream is queue byte n+1
    dsi_cq_txsel #(.QDEPTH(QDEPTH), .BA_W(BA_W)) u_txsel (
        .q_words   (q_words),
        .byte_addr (BA_W'(cnt_q + LEN_W'(1))),
        .byte_o    (tx_byte)
    );

    dsi_cq_rxcap #(.RX_BYTES(RX_BYTES), .KEEP(RX_KEEP)) u_rxcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok && w0_read),
        .rx_valid (rx_valid && (state_q == ST_LISTEN)),
        .rx_byte  (rx_byte),
        .rx_words (rx_words)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_DONE] = (send_done && !rd_cmd_q) || rx_end;
        flag_set[FLAG_RDY]  = rx_end;
    end

    dsi_cq_irq #(.NF(NFLAG)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flag_set),
        .wr_en   (stat_wr),
        .wr_keep (reg_wdata[NFLAG-1:0]),
        .enable  (int_en_q),
        .flags   (flags),
        .irq_n   (irq_n)
    );

    // ---------------- register read ----------------
    always_comb begin
        reg_rdata = '0;
        if (q_hit) begin
            reg_rdata = q_words[qidx];
        end else if (rx_hit) begin
            reg_rdata = rx_words[rxidx];
        end else if (reg_addr == ADDR_W'(REG_STAT)) begin
            reg_rdata[NFLAG-1:0] = flags;
            reg_rdata[BUSY_BIT]  = busy;
        end else if (reg_addr == ADDR_W'(REG_IEN)) begin
            reg_rdata[NFLAG-1:0] = int_en_q;
        end else if (reg_addr == ADDR_W'(REG_MODE)) begin
            reg_rdata[1:0] = mode_q;
        end else if (reg_addr == ADDR_W'(REG_QSIZE)) begin
            reg_rdata[QSZ_W-1:0] = qsize_q;
        end
    end

    // ---------------- assertions ----------------
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R7
    bta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bta_o |=> !bta_o);

    // R7
    bta_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bta_o |-> !tx_valid);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_DONE]) |-> $past(busy));

    // R9
    rdy_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_RDY]) |-> busy);

endmodule

// File: tb/dsi_cq_engine_bench.sv
module dsi_cq_engine_bench;
    import dsi_cq_pkg::*;

    localparam int AW = 6;
    localparam int QB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic tx_valid, tx_last, bta_o, irq_n;
    logic [7:0] tx_byte;
    logic tx_ready = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_last = 1'b0;

    always #10 clk = ~clk;

    dsi_cq_engine u_dsi_cq_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready), .bta_o(bta_o),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .irq_n(irq_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] exp_b [0:79];
    int exp_n;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = AW'(REG_STAT);
        #1;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    // start the loaded command and consume exp_n bytes
    task automatic send(input int pat, input string tag);
        int got = 0;
        int guard = 0;
        bit prev_stall = 1'b0;
        bit busy_seen = 1'b0;
        logic [7:0] prev_b = '0;
        bit rdy;
        tx_ready = 1'b0;
        wr(REG_START, 32'h1);
        while (got < exp_n && guard < 3000) begin
            reg_addr = AW'(REG_STAT);
            #1;
            if (!busy_seen) begin
                chk(reg_rdata[BUSY_BIT] == 1'b1, "R6 busy after start", reg_rdata, 32'h8000_0000);
                busy_seen = 1'b1;
            end
            if (prev_stall)
                chk(tx_valid && tx_byte == prev_b, "R4 byte held under stall", tx_byte, prev_b);
            rdy = (pat == 0) ? 1'b1 : ((guard % (pat + 1)) != 0);
            tx_ready = rdy;
            if (tx_valid && rdy) begin
                chk(tx_byte == exp_b[got], tag, tx_byte, exp_b[got]);
                chk(tx_last == (got == exp_n - 1), "R2 R3 tx_last position", tx_last, (got == exp_n - 1));
                got++;
            end
            prev_stall = tx_valid && !rdy;
            prev_b = tx_byte;
            guard++;
            @(negedge clk);
        end
        tx_ready = 1'b0;
        #1;
        chk(got == exp_n, "R2 R3 byte count", got, exp_n);
    endtask

    function automatic logic [7:0] pay(input int j, input int n);
        return 8'(j * 37 + n * 5 + 1);
    endfunction

    function automatic logic [7:0] resp(input int k, input int n);
        return 8'(n * 19 + k * 3 + 1);
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] expw;
        // ---------- R1 reset ----------
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(REG_STAT, d);
        chk(d == 32'h0, "R1 status after reset", d, 0);
        chk(irq_n == 1'b1 && tx_valid == 1'b0 && bta_o == 1'b0, "R1 outputs idle",
            {irq_n, tx_valid, bta_o}, 3'b100);

        wr(REG_IEN, 32'h3);

        // ---------- R2 short packet sweep ----------
        for (int i = 0; i < 8; i++) begin
            logic [7:0] di, p0, p1;
            di = 8'(i * 33 + 5); p0 = 8'(i * 17); p1 = ~8'(i);
            wr(QB, {p1, p0, di, 8'h00});
            wr(REG_QSIZE, 32'd1);
            exp_b[0] = di; exp_b[1] = p0; exp_b[2] = p1; exp_n = 3;
            send(i % 3, "R2 short packet byte");
            rd(REG_STAT, d);
            chk(d == 32'h2, "R6 done set and busy low", d, 32'h2);
            chk(irq_n == 1'b0, "R11 irq on enabled done", irq_n, 0);
            wr(REG_STAT, 32'h0);
            rd(REG_STAT, d);
            chk(d == 32'h0, "R10 write zero clears", d, 0);
            chk(irq_n == 1'b1, "R11 irq released", irq_n, 1);
        end

        // ---------- R3 long packet sweep ----------
        for (int n = 0; n <= 12; n++) begin
            logic [7:0] di;
            di = 8'(8'h29 + n);
            wr(QB, {16'(n), di, 8'h02});
            for (int w = 0; w < (n + 3) / 4; w++)
                wr(QB + 1 + w, {pay(4*w+3, n), pay(4*w+2, n), pay(4*w+1, n), pay(4*w, n)});
            wr(REG_QSIZE, 32'(1 + (n + 3) / 4));
            exp_b[0] = di; exp_b[1] = 8'(n); exp_b[2] = 8'(n >> 8);
            for (int j = 0; j < n; j++) exp_b[3 + j] = pay(j, n);
            exp_n = 3 + n;
            send(n % 3, "R3 long packet byte");
            rd(REG_STAT, d);
            chk(d == 32'h2, "R6 long done", d, 32'h2);
            wr(REG_STAT, 32'h0);
        end

        // ---------- R5 ignored starts ----------
        wr(QB, 32'h0000_0500);
        wr(REG_MODE, 32'h1);
        wr(REG_START, 32'h1);
        for (int k = 0; k < 3; k++) begin
            rd(REG_STAT, d);
            chk(tx_valid == 1'b0 && d[BUSY_BIT] == 1'b0, "R5 start in video mode", {tx_valid, d[BUSY_BIT]}, 0);
            @(negedge clk);
        end
        wr(REG_MODE, 32'h0);
        wr(REG_QSIZE, 32'h0);
        wr(REG_START, 32'h1);
        for (int k = 0; k < 3; k++) begin
            rd(REG_STAT, d);
            chk(tx_valid == 1'b0 && d[BUSY_BIT] == 1'b0, "R5 start with empty queue", {tx_valid, d[BUSY_BIT]}, 0);
            @(negedge clk);
        end
        wr(REG_QSIZE, 32'h1);

        // ---------- R7 R8 R9 read sweep ----------
        for (int n = 16; n >= 1; n--) begin
            logic [7:0] di;
            di = 8'(8'h06 + n);
            wr(QB, {8'h00, 8'(n), di, 8'h04});
            exp_b[0] = di; exp_b[1] = 8'(n); exp_b[2] = 8'h00; exp_n = 3;
            send(n % 3, "R2 read request byte");
            chk(bta_o == 1'b1 && tx_valid == 1'b0, "R7 turnaround after last byte", {bta_o, tx_valid}, 2'b10);
            @(negedge clk);
            chk(bta_o == 1'b0, "R7 turnaround one cycle", bta_o, 0);
            for (int k = 0; k < n; k++) begin
                rx_valid = 1'b1; rx_byte = resp(k, n); rx_last = (k == n - 1);
                @(negedge clk);
            end
            rx_valid = 1'b0; rx_last = 1'b0;
            rd(REG_STAT, d);
            chk(d == 32'h8000_0003, "R9 flags and busy after response", d, 32'h8000_0003);
            for (int w = 0; w < 4; w++) begin
                expw = '0;
                for (int b = 0; b < 4; b++)
                    if ((4*w + b) < n && (4*w + b) < 14) expw[8*b +: 8] = resp(4*w + b, n);
                rd(REG_RX0 + w, d);
                chk(d == expw, "R8 rx word placement", d, expw);
            end
            if (n == 5) begin
                // R5: start while holding is ignored
                wr(REG_START, 32'h1);
                wr(REG_RACK, 32'h0);
                rd(REG_STAT, d);
                chk(d[BUSY_BIT] == 1'b1 && tx_valid == 1'b0, "R9 ack of zero ignored", d, 32'h8000_0003);
                wr(REG_STAT, 32'h2);
                rd(REG_STAT, d);
                chk(d[1:0] == 2'b10, "R10 keep-one clear-zero", d[1:0], 2'b10);
            end
            wr(REG_RACK, 32'h1);
            rd(REG_STAT, d);
            chk(d[BUSY_BIT] == 1'b0, "R9 ack releases busy", d, 0);
            for (int k = 0; k < 3; k++) begin
                chk(tx_valid == 1'b0, "R5 start while busy not replayed", tx_valid, 0);
                @(negedge clk);
            end
            wr(REG_STAT, 32'h0);
        end

        // ---------- R11 enable gating ----------
        wr(REG_IEN, 32'h1);
        wr(QB, 32'h0000_3900);
        exp_b[0] = 8'h39; exp_b[1] = 8'h00; exp_b[2] = 8'h00; exp_n = 3;
        send(0, "R2 short packet byte");
        rd(REG_STAT, d);
        chk(d == 32'h2 && irq_n == 1'b1, "R11 masked done keeps irq high", irq_n, 1);
        wr(REG_IEN, 32'h2);
        chk(irq_n == 1'b0, "R11 enabled done drives irq low", irq_n, 0);
        wr(REG_STAT, 32'h0);
        chk(irq_n == 1'b1, "R11 irq high after clear", irq_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule